// File: doc/BRIEF.md
# Memory Module Row Boundary Calculator

This block turns the descriptor bytes of two memory-module slots into the cumulative row boundary values that a memory controller uses to decode addresses. For each slot it takes a type byte, a bank count, a row-density bitmask and two timing bytes. It works out the size of each module side, applies the compatibility rules, and accumulates the sizes in 32 MB units across the slots. The result is six boundary bytes: two per slot, then two top entries that repeat the final total.

A single start pulse launches a run. The block handles one slot per clock cycle. It then pulses a valid strobe for one cycle, or it stops at the first slot that breaks a rule and raises a sticky error flag with a code. The code tells which rule failed and which slot caused it. Reading the descriptor bytes from the module's serial bus happens outside this block. The bytes are expected to be stable for the whole run.

Top module: `rowBoundCalc`

## Requirements
- R1: A slot counts as populated only when its type byte is 0x04. An unpopulated slot adds 0 to both of its boundaries and never raises an error, whatever its other bytes hold.
- R2: The side-1 size of a populated slot is 4 MB times the value of the highest set bit of its density byte. It contributes that size divided by 32 (for example, bit value 8 gives 1 unit and bit value 64 gives 8 units).
- R3: Side 2 equals side 1 only when the bank count is greater than 1 and the density byte has exactly one bit set. Otherwise side 2 is 0. In particular, a module with two different densities is treated as single-sided and raises no error.
- R4: A populated slot whose cycle-time byte is not 0x75, or whose access-time byte is not 0x54, raises a timing error (kind code 2'b01). The timing check takes priority over the size checks.
- R5: A populated slot whose side-1 size is below 32 MB raises kind 2'b10, and one above 256 MB raises kind 2'b11. An empty density byte counts as below 32 MB. The error code is {slot index, kind}, with the kind in bits [1:0].
- R6: Boundary 0 is slot 0 side 1. Boundary 1 adds slot 0 side 2. Boundary 2 adds slot 1 side 1. Boundary 3 adds slot 1 side 2. Boundaries 4 and 5 equal boundary 3. All values are in 32 MB units.
- R7: When no error occurs, the valid strobe is high for exactly one cycle: the second rising edge after the edge that samples start. The error flag rises at the edge that processes the failing slot. After an error, no valid pulse follows, and a slot-0 error stops the run before slot 1 is processed.
- R8: After reset, valid, the error flag, the error code and all boundaries are 0.
- R9: A start pulse during a run is ignored. A new start clears the error flag and the error code at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| memType | input | 2x8 | Per-slot type byte |
| bankCnt | input | 2x8 | Per-slot bank count |
| density | input | 2x8 | Per-slot row-density bitmask |
| cycleTime | input | 2x8 | Per-slot cycle-time byte |
| accessTime | input | 2x8 | Per-slot access-time byte |
| bnd | output | 6x8 | Cumulative boundaries, entry 0 first |
| bndValid | output | 1 | One-cycle strobe when all six are final |
| errFlag | output | 1 | Sticky fatal-error flag |
| errCode | output | 3 | {slot, kind} of the failing check |

## Verification
The hardest case to reach is a slot-1 error that follows a clean slot 0. Reaching it needs a populated, correctly timed, in-range first module together with a faulty second one. Purely random bytes seldom produce this, because most random density or timing values already fail at slot 0. The stimulus therefore biases the random bytes towards the legal timing values and towards single-bit densities. It also adds directed cases for a slot-1 timing fault, a slot-1 size fault, an asymmetric module and a start pulse sent in the middle of a run.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int SLOTS      = 2;
  localparam int BYTE_W     = 8;
  localparam int NBND       = 2 * SLOTS + 2;
  localparam int IDX_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int ERR_W      = IDX_W + 2;
  localparam int MB_W       = BYTE_W + 4;
  localparam int MB_PER_BIT = 4;
  localparam int UNIT_MB    = 32;
  localparam int MIN_MB     = 32;
  localparam int MAX_MB     = 256;
  localparam logic [BYTE_W-1:0] TYPE_OK = 8'h04;
  localparam logic [BYTE_W-1:0] CYC_OK  = 8'h75;
  localparam logic [BYTE_W-1:0] ACC_OK  = 8'h54;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_TIMING = 2'b01,
    ERR_SMALL  = 2'b10,
    ERR_LARGE  = 2'b11
  } errKind_e;

  typedef struct packed {
    logic             clrRun;
    logic             ldStep;
    logic [IDX_W-1:0] stepIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/rbcSlotDecode.sv
module rbcSlotDecode
  import rbc_pkg::*;
(
  input  logic [BYTE_W-1:0] memType,
  input  logic [BYTE_W-1:0] bankCnt,
  input  logic [BYTE_W-1:0] density,
  input  logic [BYTE_W-1:0] cycleTime,
  input  logic [BYTE_W-1:0] accessTime,
  output errKind_e          kind,
  output logic [BYTE_W-1:0] units1,
  output logic [BYTE_W-1:0] units2
);
  logic [MB_W-1:0] s1Bit;
  logic [MB_W-1:0] s1Mb;
  logic            present;
  logic            single;
  logic            dual;

  always_comb begin
    s1Bit = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      if (density[b]) s1Bit = MB_W'(1) << b;
    end
    s1Mb    = s1Bit * MB_W'(MB_PER_BIT);
    present = (memType == TYPE_OK);
    single  = (density != '0) && (MB_W'(density) == s1Bit);
    dual    = (bankCnt > BYTE_W'(1));

    if (!present)                                        kind = ERR_NONE;
    else if (cycleTime != CYC_OK || accessTime != ACC_OK) kind = ERR_TIMING;
    else if (s1Mb < MB_W'(MIN_MB))                         kind = ERR_SMALL;
    else if (s1Mb > MB_W'(MAX_MB))                         kind = ERR_LARGE;
    else                                                  kind = ERR_NONE;

    units1 = present ? BYTE_W'(s1Mb / MB_W'(UNIT_MB)) : '0;
    units2 = (present && dual && single) ? units1 : '0;
  end
endmodule

// File: rtl/rbcDatapath.sv
module rbcDatapath
  import rbc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  ctrl,
  input  logic [SLOTS-1:0][BYTE_W-1:0] memType,
  input  logic [SLOTS-1:0][BYTE_W-1:0] bankCnt,
  input  logic [SLOTS-1:0][BYTE_W-1:0] density,
  input  logic [SLOTS-1:0][BYTE_W-1:0] cycleTime,
  input  logic [SLOTS-1:0][BYTE_W-1:0] accessTime,
  output logic                         stepErr,
  output logic [NBND-1:0][BYTE_W-1:0]  bnd,
  output logic                         errFlag,
  output logic [ERR_W-1:0]             errCode
);
  errKind_e                    kindArr [SLOTS];
  logic [SLOTS-1:0][BYTE_W-1:0] u1Arr;
  logic [SLOTS-1:0][BYTE_W-1:0] u2Arr;
  logic [BYTE_W-1:0]           acc;
  logic [BYTE_W-1:0]           sum1;
  logic [BYTE_W-1:0]           sum2;
  errKind_e                    curKind;
  logic                        lastStep;

  for (genvar k = 0; k < SLOTS; k++) begin : g_dec
    rbcSlotDecode dec_i (
      .memType   (memType[k]),
      .bankCnt   (bankCnt[k]),
      .density   (density[k]),
      .cycleTime (cycleTime[k]),
      .accessTime(accessTime[k]),
      .kind      (kindArr[k]),
      .units1    (u1Arr[k]),
      .units2    (u2Arr[k])
    );

    // R3
    side_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
      (u2Arr[k] != '0) |-> (u2Arr[k] == u1Arr[k]));
  end

  always_comb begin
    curKind  = kindArr[ctrl.stepIdx];
    stepErr  = ctrl.ldStep && (curKind != ERR_NONE);
    sum1     = acc + u1Arr[ctrl.stepIdx];
    sum2     = sum1 + u2Arr[ctrl.stepIdx];
    lastStep = (int'(ctrl.stepIdx) == SLOTS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      bnd     <= '0;
      errFlag <= 1'b0;
      errCode <= '0;
    end else if (ctrl.clrRun) begin
      acc     <= '0;
      errFlag <= 1'b0;
      errCode <= '0;
    end else if (ctrl.ldStep) begin
      if (curKind != ERR_NONE) begin
        errFlag <= 1'b1;
        errCode <= {ctrl.stepIdx, curKind};
      end else begin
        acc <= sum2;
        for (int k = 0; k < NBND; k++) begin
          if (k == 2 * int'(ctrl.stepIdx))     bnd[k] <= sum1;
          if (k == 2 * int'(ctrl.stepIdx) + 1) bnd[k] <= sum2;
          if (lastStep && k >= NBND - 2)       bnd[k] <= sum2;
        end
      end
    end
  end

  // R5
  err_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (errCode[1:0] != 2'b00));
endmodule

// File: rtl/rbcControl.sv
module rbcControl
  import rbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stepErr,
  output ctrlStrobe_t ctrl,
  output logic        bndValid
);
  logic             busy;
  logic [IDX_W-1:0] idxQ;
  logic             lastIdx;

  always_comb begin
    lastIdx      = (int'(idxQ) == SLOTS - 1);
    ctrl.clrRun  = start && !busy;
    ctrl.ldStep  = busy;
    ctrl.stepIdx = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      idxQ     <= '0;
      bndValid <= 1'b0;
    end else begin
      bndValid <= busy && lastIdx && !stepErr;
      if (ctrl.clrRun) begin
        busy <= 1'b1;
        idxQ <= '0;
      end else if (busy) begin
        if (stepErr || lastIdx) busy <= 1'b0;
        else                    idxQ <= idxQ + IDX_W'(1);
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |=> !bndValid);

  // R9
  run_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && idxQ == '0));

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepErr |=> (!busy && !bndValid));
endmodule

// File: rtl/rowBoundCalc.sv
module rowBoundCalc
  import rbc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [SLOTS-1:0][BYTE_W-1:0] memType,
  input  logic [SLOTS-1:0][BYTE_W-1:0] bankCnt,
  input  logic [SLOTS-1:0][BYTE_W-1:0] density,
  input  logic [SLOTS-1:0][BYTE_W-1:0] cycleTime,
  input  logic [SLOTS-1:0][BYTE_W-1:0] accessTime,
  output logic [NBND-1:0][BYTE_W-1:0]  bnd,
  output logic                         bndValid,
  output logic                         errFlag,
  output logic [ERR_W-1:0]             errCode
);
  ctrlStrobe_t ctrl;
  logic        stepErr;

  rbcControl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stepErr (stepErr),
    .ctrl    (ctrl),
    .bndValid(bndValid)
  );

  rbcDatapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .memType   (memType),
    .bankCnt   (bankCnt),
    .density   (density),
    .cycleTime (cycleTime),
    .accessTime(accessTime),
    .stepErr   (stepErr),
    .bnd       (bnd),
    .errFlag   (errFlag),
    .errCode   (errCode)
  );

  // R7
  valid_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> !errFlag);

  // R6
  top_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (bnd[NBND-1] == bnd[NBND-3] && bnd[NBND-2] == bnd[NBND-3]));

  // R6
  monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (bnd[1] >= bnd[0] && bnd[2] >= bnd[1] && bnd[3] >= bnd[2]));
endmodule

// File: tb/rowBoundCalc_tb_top.sv
`timescale 1ns/1ps
module rowBoundCalc_tb_top;
  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [1:0][7:0]     memType, bankCnt, density, cycleTime, accessTime;
  logic [5:0][7:0]     bnd;
  logic                bndValid, errFlag;
  logic [2:0]          errCode;

  int nChecks = 0;
  int nFails  = 0;
  int eKind [2];
  int eU1 [2];
  int eU2 [2];

  always #2.5 clk = ~clk;

  rowBoundCalc dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .memType(memType), .bankCnt(bankCnt), .density(density),
    .cycleTime(cycleTime), .accessTime(accessTime),
    .bnd(bnd), .bndValid(bndValid), .errFlag(errFlag), .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model built from R1..R5
  task automatic model();
    for (int s = 0; s < 2; s++) begin
      int hi = 0;
      int mb;
      eKind[s] = 0; eU1[s] = 0; eU2[s] = 0;
      for (int b = 0; b < 8; b++) if (density[s][b]) hi = 1 << b;
      mb = hi * 4;
      if (memType[s] == 8'h04) begin
        if (cycleTime[s] != 8'h75 || accessTime[s] != 8'h54) eKind[s] = 1;
        else if (mb < 32)  eKind[s] = 2;
        else if (mb > 256) eKind[s] = 3;
        eU1[s] = mb / 32;
        if (bankCnt[s] > 1 && density[s] != 0 && int'(density[s]) == hi) eU2[s] = eU1[s];
      end
    end
  endtask

  task automatic setSlot(input int s, input logic [7:0] t, input logic [7:0] bk,
                         input logic [7:0] d, input logic [7:0] c, input logic [7:0] a);
    memType[s] = t; bankCnt[s] = bk; density[s] = d; cycleTime[s] = c; accessTime[s] = a;
  endtask

  task automatic runTrial(input bit dbl);
    int firstErr = -1;
    int exp [6];
    model();
    for (int s = 1; s >= 0; s--) if (eKind[s] != 0) firstErr = s;
    exp[0] = eU1[0];
    exp[1] = exp[0] + eU2[0];
    exp[2] = exp[1] + eU1[1];
    exp[3] = exp[2] + eU2[1];
    exp[4] = exp[3];
    exp[5] = exp[3];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = dbl;
    check(errFlag == 1'b0, "R9", "err cleared by start", int'(errFlag), 0);
    @(negedge clk) start = 1'b0;
    if (firstErr == 0) begin
      check(errFlag == 1'b1, "R7", "slot0 err flag", int'(errFlag), 1);
      check(errCode == {1'b0, 2'(eKind[0])}, "R5", "slot0 err code", int'(errCode), eKind[0]);
      for (int w = 0; w < 3; w++) begin
        check(bndValid == 1'b0, "R7", "no valid after slot0 err", int'(bndValid), 0);
        @(negedge clk);
      end
      return;
    end
    check(bndValid == 1'b0 && errFlag == 1'b0, "R7", "mid-run quiet",
          int'({bndValid, errFlag}), 0);
    @(negedge clk);
    if (firstErr == 1) begin
      check(errFlag == 1'b1, "R7", "slot1 err flag", int'(errFlag), 1);
      check(errCode == {1'b1, 2'(eKind[1])}, "R5", "slot1 err code", int'(errCode), 4 + eKind[1]);
      check(bndValid == 1'b0, "R7", "no valid after slot1 err", int'(bndValid), 0);
    end else begin
      check(bndValid == 1'b1, "R7", "valid on second edge", int'(bndValid), 1);
      for (int i = 0; i < 6; i++)
        check(int'(bnd[i]) == exp[i], "R6", $sformatf("boundary %0d", i), int'(bnd[i]), exp[i]);
    end
    @(negedge clk);
    check(bndValid == 1'b0, "R7", "valid one cycle", int'(bndValid), 0);
    if (dbl) begin
      @(negedge clk);
      check(bndValid == 1'b0, "R9", "start during run ignored", int'(bndValid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 2; s++) setSlot(s, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(bndValid == 1'b0 && errFlag == 1'b0 && errCode == 3'd0 && bnd == '0,
          "R8", "reset state", int'({bndValid, errFlag, errCode}), 0);

    // R1: both absent, bad bytes ignored
    setSlot(0, 8'h02, 8'h02, 8'hFF, 8'h11, 8'h22);
    setSlot(1, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
    runTrial(1'b0);
    // R2/R3/R6: 256MB dual symmetric then 32MB single
    setSlot(0, 8'h04, 8'h02, 8'h40, 8'h75, 8'h54);
    setSlot(1, 8'h04, 8'h01, 8'h08, 8'h75, 8'h54);
    runTrial(1'b0);
    // R3: asymmetric downgraded, no error; R9 restart mid-run
    setSlot(0, 8'h04, 8'h02, 8'h48, 8'h75, 8'h54);
    setSlot(1, 8'h04, 8'h02, 8'h10, 8'h75, 8'h54);
    runTrial(1'b1);
    // R5: slot1 too small
    setSlot(1, 8'h04, 8'h02, 8'h04, 8'h75, 8'h54);
    runTrial(1'b0);
    // R5: slot0 too large
    setSlot(0, 8'h04, 8'h01, 8'h80, 8'h75, 8'h54);
    runTrial(1'b0);
    // R4: slot0 bad cycle time beats size fault; R9 clears previous error
    setSlot(0, 8'h04, 8'h01, 8'h01, 8'h74, 8'h54);
    runTrial(1'b0);
    // R4: slot1 bad access time
    setSlot(0, 8'h04, 8'h01, 8'h20, 8'h75, 8'h54);
    setSlot(1, 8'h04, 8'h02, 8'h20, 8'h75, 8'h55);
    runTrial(1'b0);
    // R5: empty density counts as too small
    setSlot(0, 8'h04, 8'h02, 8'h00, 8'h75, 8'h54);
    runTrial(1'b0);

    for (int n = 0; n < 400; n++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] t, bk, d, c, a;
        t  = ($urandom % 5 == 0) ? 8'($urandom) : 8'h04;
        bk = 8'(1 + $urandom % 3);
        d  = ($urandom % 3 == 0) ? 8'($urandom) : 8'(1 << (3 + $urandom % 4));
        c  = ($urandom % 10 == 0) ? 8'($urandom) : 8'h75;
        a  = ($urandom % 10 == 0) ? 8'($urandom) : 8'h54;
        setSlot(s, t, bk, d, c, a);
      end
      runTrial(1'($urandom % 8 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule